// File: doc/BRIEF.md
# Byte-Lane Data Memory With Alignment Checking

This block is the data store of a small processor datapath. It keeps a parameterised number of 32-bit words, addressed by a 32-bit byte address, and serves one access per cycle. A 2-bit operation code selects the access. One code is a full word read. The other three codes write one byte, a halfword or a full word. Each write changes only the bytes it covers, and the other bytes of the word keep their values.

Reads are combinational. Writes take effect on the rising clock edge. Halfword and word accesses must be aligned to their size. When an enabled access is misaligned, the error output goes high for that cycle and the store is not changed. Byte order is little-endian. Only the address bits that index the internal array take part in the access, so addresses that differ only above those bits refer to the same location.

Top module: `dmem_ctrl`

## Requirements
- R1: While reset is held low, every stored word is cleared to zero and `err` is low.
- R2: With `en` high and `op` = 2'b00 (word read), `rdata` shows the stored word at index `addr[IDX_W+1:2]` in the same cycle, with `addr[1:0]` ignored. A read never changes the store.
- R3: When `en` is low or `op` is not 2'b00, `rdata` is zero.
- R4: `op` = 2'b01 (byte write) with `en` high stores `wdata[7:0]` into byte `addr[1:0]` of the word (byte 0 is bits 7:0) at any byte address, and leaves the other three bytes unchanged.
- R5: `op` = 2'b10 (halfword write) with `en` high and `addr[0]` = 0 stores `wdata[7:0]` at byte `addr` and `wdata[15:8]` at byte `addr+1`. The other halfword is unchanged.
- R6: `op` = 2'b11 (word write) with `en` high and `addr[1:0]` = 0 replaces the whole word with `wdata` at the next rising edge.
- R7: With `en` high, a halfword write with `addr[0]` = 1, or a word read or word write with `addr[1:0]` != 0, drives `err` high in that cycle and leaves every stored word unchanged. A misaligned word read still returns the aligned word.
- R8: With `en` low, nothing is written and `err` stays low, whatever `op`, `addr` and `wdata` are.
- R9: Address bits above `IDX_W+1` are ignored, so two addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Access enable |
| op | input | 2 | 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, low-aligned for byte and halfword writes |
| rdata | output | 32 | Read data for word reads, zero otherwise |
| err | output | 1 | High in a cycle that carries an enabled misaligned access |

## Verification
Some properties are checked on every cycle. No lane is enabled while `err` is high, while `en` is low, or during a read. A byte write enables exactly one lane and an aligned halfword write exactly two. The whole store stays stable across any cycle with no lane enabled, and a full-word write lands at the row that was addressed. These checks do not show which byte positions a write reaches or what value it leaves in the store. Only the bench's scenarios show that, together with the zero state after reset, the zero read output and address aliasing, because each of them needs a write followed by a read-back compared against a model of the store.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    OP_RD_WORD = 2'b00,
    OP_WR_BYTE = 2'b01,
    OP_WR_HALF = 2'b10,
    OP_WR_WORD = 2'b11
  } dmem_op_e;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;
endpackage

// File: rtl/dmem_align_chk.sv
module dmem_align_chk
  import dmem_pkg::*;
(
  input  logic       en,
  input  dmem_op_e   op,
  input  logic [1:0] lo_addr,
  output logic       err,
  output logic       ok
);
  logic misaligned;

  always_comb begin
    unique case (op)
      OP_WR_BYTE: misaligned = 1'b0;
      OP_WR_HALF: misaligned = lo_addr[0];
      default:    misaligned = (lo_addr != 2'b00);
    endcase
  end

  assign err = en & misaligned;
  assign ok  = en & ~misaligned;
endmodule

// File: rtl/dmem_lane_gen.sv
module dmem_lane_gen
  import dmem_pkg::*;
(
  input  logic                     ok,
  input  dmem_op_e                 op,
  input  logic [1:0]               lo_addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [LANES-1:0]         be,
  output logic [WORD_W-1:0]        lane_data
);
  logic [LANES-1:0] be_raw;

  always_comb begin
    be_raw    = '0;
    lane_data = wdata;
    unique case (op)
      OP_WR_BYTE: begin
        be_raw             = LANES'(1) << lo_addr;
        lane_data          = {LANES{wdata[LANE_W-1:0]}};
      end
      OP_WR_HALF: begin
        be_raw             = lo_addr[1] ? 4'b1100 : 4'b0011;
        lane_data          = {2{wdata[2*LANE_W-1:0]}};
      end
      OP_WR_WORD: begin
        be_raw             = '1;
        lane_data          = wdata;
      end
      default: begin
        be_raw             = '0;
        lane_data          = wdata;
      end
    endcase
  end

  assign be = ok ? be_raw : '0;
endmodule

// File: rtl/dmem_bank.sv
module dmem_bank
  import dmem_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      row,
  input  logic [LANES-1:0]      be,
  input  logic [WORD_W-1:0]     lane_data,
  output logic [WORD_W-1:0]     row_q
);
  logic [DEPTH_WORDS-1:0][WORD_W-1:0] mem_q;
  logic [DEPTH_WORDS-1:0][WORD_W-1:0] mem_d;
  logic [DEPTH_WORDS-1:0]             row_ce;

  for (genvar w = 0; w < DEPTH_WORDS; w++) begin : g_row
    assign row_ce[w] = (row == IDX_W'(w)) && (be != '0);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_comb begin
        mem_d[w][b*LANE_W +: LANE_W] = be[b] ? lane_data[b*LANE_W +: LANE_W]
                                             : mem_q[w][b*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[w] <= '0;
      end else if (row_ce[w]) begin
        mem_q[w] <= mem_d[w];
      end
    end
  end

  assign row_q = mem_q[row];

  // R8
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be == '0) |=> $stable(mem_q));

  // R6
  word_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be == '1) |=> (mem_q[$past(row)] == $past(lane_data)));
endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  op,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        err
);
  dmem_op_e           op_e;
  logic               ok;
  logic [LANES-1:0]   be;
  logic [WORD_W-1:0]  lane_data;
  logic [WORD_W-1:0]  row_q;
  logic [IDX_W-1:0]   row;
  logic               unused_hi;

  assign op_e      = dmem_op_e'(op);
  assign row       = addr[IDX_W+1:2];
  assign unused_hi = ^addr[31:IDX_W+2];

  dmem_align_chk u_align (
    .en      (en),
    .op      (op_e),
    .lo_addr (addr[1:0]),
    .err     (err),
    .ok      (ok)
  );

  dmem_lane_gen u_lanes (
    .ok        (ok),
    .op        (op_e),
    .lo_addr   (addr[1:0]),
    .wdata     (wdata),
    .be        (be),
    .lane_data (lane_data)
  );

  dmem_bank #(.DEPTH_WORDS(DEPTH_WORDS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .row       (row),
    .be        (be),
    .lane_data (lane_data),
    .row_q     (row_q)
  );

  assign rdata = (en && op_e == OP_RD_WORD) ? row_q : '0;

  // R7
  err_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (be == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!err && be == '0));

  // R2
  read_no_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_RD_WORD) |-> (be == '0));

  // R4
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_e == OP_WR_BYTE) |-> ($countones(be) == 1 && !err));

  // R5
  half_two_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_e == OP_WR_HALF && !addr[0]) |-> ($countones(be) == 2));
endmodule

// File: tb/dmem_ctrl_test.sv
`timescale 1ns/1ps
module dmem_ctrl_test;
  localparam int DEPTH = 64;
  localparam int SPAN  = DEPTH * 4;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [1:0]  op;
  logic [31:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;

  int checks;
  int errors;
  logic [31:0] model [DEPTH];

  dmem_ctrl #(.DEPTH_WORDS(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    en = 1'b0; op = 2'b00; addr = 32'h0; wdata = 32'h0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    en = 1'b1; op = 2'b00; addr = a;
    #1;
    d = rdata; e = err;
  endtask

  task automatic wr(input logic [1:0] o, input logic [31:0] a, input logic [31:0] d,
                    output logic e);
    @(negedge clk);
    en = 1'b1; op = o; addr = a; wdata = d;
    #1;
    e = err;
    @(negedge clk);
    en = 1'b0;
  endtask

  function automatic int idx(input logic [31:0] a);
    return int'((a % SPAN) / 4);
  endfunction

  task automatic t_reset();
    logic [31:0] d; logic e;
    for (int i = 0; i < DEPTH; i++) model[i] = 32'h0;
    rst_n = 1'b0; en = 1'b0; op = 2'b00; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    check("R1 err in reset", {31'b0, err}, 32'h0);
    rst_n = 1'b1;
    rd(32'h0000_0010, d, e);
    check("R1 word zero after reset", d, 32'h0);
    rd(32'h0000_00FC, d, e);
    check("R1 last word zero after reset", d, 32'h0);
    idle();
  endtask

  task automatic t_word();
    logic [31:0] d; logic e;
    wr(2'b11, 32'h0000_0020, 32'hDEAD_BEEF, e);
    model[idx(32'h20)] = 32'hDEAD_BEEF;
    check("R6 no err aligned word write", {31'b0, e}, 32'h0);
    rd(32'h0000_0020, d, e);
    check("R6/R2 word read back", d, model[idx(32'h20)]);
    wr(2'b11, 32'h0000_0024, 32'h1234_5678, e);
    model[idx(32'h24)] = 32'h1234_5678;
    rd(32'h0000_0024, d, e);
    check("R2 second word", d, 32'h1234_5678);
    rd(32'h0000_0020, d, e);
    check("R2 neighbour unchanged", d, 32'hDEAD_BEEF);
    idle();
    #1 check("R3 rdata zero when idle", rdata, 32'h0);
    @(negedge clk);
    en = 1'b1; op = 2'b11; addr = 32'h0000_0020; wdata = 32'h0;
    #0.5 check("R3 rdata zero on write op", rdata, 32'h0);
    en = 1'b0;
    idle();
  endtask

  task automatic t_byte();
    logic [31:0] d; logic e;
    for (int b = 0; b < 4; b++) begin
      logic [31:0] a;
      a = 32'h0000_0040 + b;
      wr(2'b01, a, 32'hFFFF_FF00 | (8'h11 * (b + 1)), e);
      model[idx(a)][b*8 +: 8] = 8'h11 * (b + 1);
      check("R4 byte write no err", {31'b0, e}, 32'h0);
      rd(32'h0000_0040, d, e);
      check("R4 byte lane placement", d, model[idx(a)]);
    end
    wr(2'b11, 32'h0000_0044, 32'hAABB_CCDD, e);
    model[idx(32'h44)] = 32'hAABB_CCDD;
    wr(2'b01, 32'h0000_0046, 32'h0000_0099, e);
    model[idx(32'h44)][23:16] = 8'h99;
    rd(32'h0000_0044, d, e);
    check("R4 other bytes kept", d, 32'hAA99_CCDD);
    idle();
  endtask

  task automatic t_half();
    logic [31:0] d; logic e;
    wr(2'b11, 32'h0000_0050, 32'h0102_0304, e);
    wr(2'b10, 32'h0000_0050, 32'hFFFF_BEEF, e);
    check("R5 aligned half no err", {31'b0, e}, 32'h0);
    rd(32'h0000_0050, d, e);
    check("R5 low half", d, 32'h0102_BEEF);
    wr(2'b10, 32'h0000_0052, 32'h0000_CAFE, e);
    rd(32'h0000_0050, d, e);
    check("R5 high half", d, 32'hCAFE_BEEF);
    model[idx(32'h50)] = 32'hCAFE_BEEF;
    idle();
  endtask

  task automatic t_misalign();
    logic [31:0] d; logic e;
    wr(2'b10, 32'h0000_0051, 32'h0000_1111, e);
    check("R7 half odd err", {31'b0, e}, 32'h1);
    wr(2'b11, 32'h0000_0052, 32'h2222_2222, e);
    check("R7 word off-by-2 err", {31'b0, e}, 32'h1);
    wr(2'b11, 32'h0000_0053, 32'h3333_3333, e);
    check("R7 word off-by-3 err", {31'b0, e}, 32'h1);
    rd(32'h0000_0051, d, e);
    check("R7 misaligned read err", {31'b0, e}, 32'h1);
    check("R7 misaligned read returns aligned word / store unchanged", d, model[idx(32'h50)]);
    rd(32'h0000_0050, d, e);
    check("R7 aligned read no err", {31'b0, e}, 32'h0);
    idle();
  endtask

  task automatic t_idle();
    logic [31:0] d; logic e;
    for (int o = 1; o < 4; o++) begin
      @(negedge clk);
      en = 1'b0; op = 2'(o); addr = 32'h0000_0041; wdata = 32'h5555_5555;
      #1 check("R8 err low when disabled", {31'b0, err}, 32'h0);
    end
    rd(32'h0000_0040, d, e);
    check("R8 no write when disabled", d, model[idx(32'h40)]);
    idle();
  endtask

  task automatic t_alias();
    logic [31:0] d; logic e;
    wr(2'b11, 32'hF000_0000 + SPAN + 32'h8, 32'h0BAD_F00D, e);
    model[idx(32'h8)] = 32'h0BAD_F00D;
    rd(32'h0000_0008, d, e);
    check("R9 high bits ignored on write", d, 32'h0BAD_F00D);
    rd(32'h8000_0000 + 2 * SPAN + 32'h8, d, e);
    check("R9 high bits ignored on read", d, 32'h0BAD_F00D);
    idle();
  endtask

  logic done;

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    t_reset();
    t_word();
    t_byte();
    t_half();
    t_misalign();
    t_idle();
    t_alias();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule